// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges five reset requests into one synchronous system reset and runs the release sequence for the rest of the chip. Two of the sources are levels held by the outside world. The first is an active-low external reset pin. The second is a low-voltage detector flag that reads 0 while the supply or a monitored external input is below its threshold. A power-on-clear flag also reads 0 while the supply is too low. It serves as the asynchronous reset of the controller itself and as the fifth request source. The remaining two sources are single-cycle strobes: a watchdog overflow, and an illegal-opcode strobe that the instruction decoder raises when it executes opcode FFh.

The external pin passes through a two-flop synchronizer and a minimum-width filter, so glitches are discarded. The detector flag is also synchronized. Each strobe is stretched to a fixed number of cycles, so those sources release themselves. The illegal-opcode strobe is masked while the debug-mode input is high.

While any request is active, the controller does four things. It holds the core in reset, stops the oscillators, gates the external clock input off, and places the general pins in high impedance while forcing one designated port output low. Once the last request clears, the oscillators restart and a stabilization counter runs. The pins stay tri-stated and the core stays in reset until that count ends. The core reset then drops, and a one-cycle strobe tells the core to fetch its reset vector from addresses 0000h/0001h. A sticky cause register reports which sources produced the most recent reset, and an acknowledge input clears it.

Top module: `rst_hub`

## Requirements
- R1: While any request is active, `core_rst`, `osc_stop` and `pins_hiz` are 1 and `ext_clk_en` is 0.
- R2: A low level on `pin_rst_n` counts only after it has been held for PIN_MIN_US times CLK_MHZ synchronized cycles. A shorter low pulse is discarded and `core_rst` stays 0.
- R3: A qualified pin reset holds `osc_stop` at 1 for as long as the pin stays low, and releases only after the pin returns high.
- R4: A one-cycle `wdt_ovf` or `illegal_op` strobe taken while running holds `osc_stop` at 1 for exactly PULSE_CYC cycles, and then the controller releases on its own.
- R5: While `debug_mode` is 1, an `illegal_op` strobe is ignored and `core_rst` stays 0.
- R6: While `lvd_ok` is 0, the reset is held. If `lvd_ok` is 0 at a clock edge, then `osc_stop` is 1 three edges later. Release follows automatically after `lvd_ok` returns to 1.
- R7: After the last request clears, `osc_stop` is 0 while `core_rst` and `pins_hiz` stay 1 for exactly STAB_CYC cycles, and then `core_rst` drops.
- R8: `vec_fetch` is a one-cycle pulse that is high in the first cycle in which `core_rst` is 0 after a reset.
- R9: `cause` bit encoding: [0] pin, [1] watchdog, [2] power-on-clear, [3] low-voltage, [4] illegal opcode. A reset that starts from the running state replaces `cause` with the active requests. Further requests that arrive before release are ORed in. `cause_ack` set to 1 for one cycle loads the currently active requests, which is 0 when no request is active.
- R10: `port_drive_low` is 1 whenever `pins_hiz` is 1, and `pins_hiz` always equals `core_rst`.
- R11: While `poc_ok` is 0, the block is held in reset asynchronously with `core_rst` = 1 and `cause` = 5'b00100. Release after `poc_ok` rises follows R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (internal oscillator) |
| poc_ok | input | 1 | Power-on-clear flag, 0 = supply below threshold (asynchronous) |
| pin_rst_n | input | 1 | External reset pin, active low (asynchronous) |
| lvd_ok | input | 1 | Low-voltage detector flag, 0 = below threshold (asynchronous) |
| wdt_ovf | input | 1 | Watchdog overflow strobe |
| illegal_op | input | 1 | Opcode FFh executed strobe |
| debug_mode | input | 1 | Debug mode, masks illegal_op |
| cause_ack | input | 1 | Acknowledge of cause register read |
| core_rst | output | 1 | Core reset, active high |
| osc_stop | output | 1 | Stop oscillators |
| ext_clk_en | output | 1 | External clock input accepted |
| pins_hiz | output | 1 | Tri-state all general pins |
| port_drive_low | output | 1 | Force the designated port output low |
| vec_fetch | output | 1 | One-cycle start-from-reset-vector strobe |
| cause | output | 5 | Sticky reset cause bits |

## Verification
The main function is exercised with several patterns, and each one separates a different mechanism.
- A power-on ramp.
- A short and a long low pulse on the pin, which separate the width filter from pin level holding.
- Lone watchdog and illegal-opcode strobes, whose exact `osc_stop` length shows the stretcher is the only thing holding reset.
- An illegal-opcode strobe in debug mode, which must have no effect.
- A low-voltage interval, which separates a held level from a pulse.
- A watchdog strobe that lands while the low-voltage reset is already active, which shows OR-accumulation of `cause` versus replacement.

A scoreboard pairs every expected release with the `cause` value seen at `vec_fetch`, and the stabilization gap is counted on every release.

// File: rtl/rst_hub_pkg.sv
package rst_hub_pkg;
  localparam int unsigned NSRC    = 5;
  localparam int unsigned SRC_PIN = 0;
  localparam int unsigned SRC_WDT = 1;
  localparam int unsigned SRC_POC = 2;
  localparam int unsigned SRC_LVD = 3;
  localparam int unsigned SRC_ILL = 4;

  typedef logic [NSRC-1:0] src_vec_t;

  typedef enum logic [1:0] {
    ST_HOLD   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RUN    = 2'd2
  } rel_state_t;
endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 #(
  parameter logic INIT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= INIT;
      s2_q <= INIT;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int unsigned MIN_CYC = 320
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic req
);
  localparam int unsigned CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_CYC);

  logic          pin_s;
  logic [CW-1:0] low_cnt_q;

  rst_sync2 #(.INIT(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_n),
    .q     (pin_s)
  );

  // Count synchronized low cycles, saturating at the qualification width.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
    end else if (pin_s) begin
      low_cnt_q <= '0;
    end else if (low_cnt_q != CMAX) begin
      low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  assign req = (low_cnt_q == CMAX);
endmodule

// File: rtl/rst_pulse_stretch.sv
module rst_pulse_stretch #(
  parameter int unsigned LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic req
);
  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] CLEN = CW'(LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (strobe) begin
      cnt_q <= CLEN;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign req = (cnt_q != '0);
endmodule

// File: rtl/rst_release_fsm.sv
module rst_release_fsm
  import rst_hub_pkg::*;
#(
  parameter int unsigned STAB_CYC = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_req,
  output logic in_hold,
  output logic in_run,
  output logic start_new,
  output logic vec_pulse
);
  localparam int unsigned CW = $clog2(STAB_CYC + 1);
  localparam logic [CW-1:0] CLAST = CW'(STAB_CYC - 1);

  rel_state_t    state_q;
  logic [CW-1:0] cnt_q;
  logic          vec_q;
  logic          settle_done;

  assign settle_done = (state_q == ST_SETTLE) && !any_req && (cnt_q == CLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
      vec_q   <= 1'b0;
    end else begin
      vec_q <= settle_done;
      unique case (state_q)
        ST_HOLD: begin
          cnt_q <= '0;
          if (!any_req) state_q <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (any_req) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
          end else if (settle_done) begin
            state_q <= ST_RUN;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (any_req) state_q <= ST_HOLD;
        end
      endcase
    end
  end

  assign in_hold   = (state_q == ST_HOLD);
  assign in_run    = (state_q == ST_RUN);
  assign start_new = (state_q == ST_RUN) && any_req;
  assign vec_pulse = vec_q;
endmodule

// File: rtl/rst_hub.sv
module rst_hub
  import rst_hub_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 32,
  parameter int unsigned PIN_MIN_US = 10,
  parameter int unsigned PULSE_CYC  = 64,
  parameter int unsigned STAB_CYC   = 256
) (
  input  logic            clk,
  input  logic            poc_ok,
  input  logic            pin_rst_n,
  input  logic            lvd_ok,
  input  logic            wdt_ovf,
  input  logic            illegal_op,
  input  logic            debug_mode,
  input  logic            cause_ack,
  output logic            core_rst,
  output logic            osc_stop,
  output logic            ext_clk_en,
  output logic            pins_hiz,
  output logic            port_drive_low,
  output logic            vec_fetch,
  output logic [NSRC-1:0] cause
);
  localparam int unsigned PIN_MIN_CYC = CLK_MHZ * PIN_MIN_US;
  localparam int unsigned NPULSE      = 2;

  logic        rst_n_int;
  logic        lvd_s;
  src_vec_t    req;
  logic [NPULSE-1:0] strobes;
  logic [NPULSE-1:0] pulse_req;
  logic        any_req;
  logic        in_hold, in_run, start_new, vec_pulse;
  src_vec_t    cause_q;

  // Controller reset: asserted asynchronously by power-on-clear, released synchronously.
  rst_sync2 #(.INIT(1'b0)) u_poc_sync (
    .clk   (clk),
    .rst_n (poc_ok),
    .d     (1'b1),
    .q     (rst_n_int)
  );

  rst_pin_filter #(.MIN_CYC(PIN_MIN_CYC)) u_pin (
    .clk   (clk),
    .rst_n (rst_n_int),
    .pin_n (pin_rst_n),
    .req   (req[SRC_PIN])
  );

  rst_sync2 #(.INIT(1'b1)) u_lvd_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d     (lvd_ok),
    .q     (lvd_s)
  );

  assign strobes = {illegal_op & ~debug_mode, wdt_ovf};

  for (genvar g = 0; g < NPULSE; g++) begin : g_stretch
    rst_pulse_stretch #(.LEN(PULSE_CYC)) u_str (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .strobe (strobes[g]),
      .req    (pulse_req[g])
    );
  end

  assign req[SRC_WDT] = pulse_req[0];
  assign req[SRC_ILL] = pulse_req[1];
  assign req[SRC_LVD] = ~lvd_s;
  assign req[SRC_POC] = ~rst_n_int;
  assign any_req      = |req;

  rst_release_fsm #(.STAB_CYC(STAB_CYC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .any_req   (any_req),
    .in_hold   (in_hold),
    .in_run    (in_run),
    .start_new (start_new),
    .vec_pulse (vec_pulse)
  );

  // Sticky cause: replaced on a fresh reset or acknowledge, accumulated otherwise.
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      cause_q <= src_vec_t'(1) << SRC_POC;
    end else if (start_new || cause_ack) begin
      cause_q <= req;
    end else begin
      cause_q <= cause_q | req;
    end
  end

  assign core_rst       = ~in_run;
  assign pins_hiz       = ~in_run;
  assign port_drive_low = ~in_run;
  assign osc_stop       = in_hold;
  assign ext_clk_en     = ~in_hold;
  assign vec_fetch      = vec_pulse;
  assign cause          = cause_q;
endmodule

// File: rtl/rst_hub_checker.sv
module rst_hub_checker (
  input logic clk,
  input logic poc_ok,
  input logic lvd_ok,
  input logic core_rst,
  input logic osc_stop,
  input logic ext_clk_en,
  input logic pins_hiz,
  input logic port_drive_low,
  input logic vec_fetch
);
  assert_osc_in_reset_R1: assert property (@(posedge clk) disable iff (!poc_ok)
    osc_stop |-> (core_rst && pins_hiz && !ext_clk_en));

  assert_lvd_holds_R6: assert property (@(posedge clk) disable iff (!poc_ok)
    $past(!lvd_ok, 3) |-> osc_stop);

  assert_vec_single_R8: assert property (@(posedge clk) disable iff (!poc_ok)
    vec_fetch |=> !vec_fetch);

  assert_vec_at_release_R8: assert property (@(posedge clk) disable iff (!poc_ok)
    $fell(core_rst) |-> vec_fetch);

  assert_port_low_R10: assert property (@(posedge clk) disable iff (!poc_ok)
    pins_hiz |-> port_drive_low);

  assert_hiz_tracks_R10: assert property (@(posedge clk) disable iff (!poc_ok)
    pins_hiz == core_rst);
endmodule

bind rst_hub rst_hub_checker u_chk (
  .clk            (clk),
  .poc_ok         (poc_ok),
  .lvd_ok         (lvd_ok),
  .core_rst       (core_rst),
  .osc_stop       (osc_stop),
  .ext_clk_en     (ext_clk_en),
  .pins_hiz       (pins_hiz),
  .port_drive_low (port_drive_low),
  .vec_fetch      (vec_fetch)
);

// File: tb/rst_hub_test.sv
module rst_hub_test;
  localparam int MHZ = 2, MUS = 10, PUL = 8, STB = 16;
  localparam int MINC = MHZ * MUS;

  logic clk = 1'b0;
  logic poc_ok = 1'b0, pin_rst_n = 1'b1, lvd_ok = 1'b1;
  logic wdt_ovf = 1'b0, illegal_op = 1'b0, debug_mode = 1'b0, cause_ack = 1'b0;
  logic core_rst, osc_stop, ext_clk_en, pins_hiz, port_drive_low, vec_fetch;
  logic [4:0] cause;

  int checks = 0, errors = 0, cyc = 0;
  logic [4:0] exp_q[$];
  logic prev_core = 1'b1;
  logic done = 1'b0;

  always #2 clk = ~clk;

  rst_hub #(.CLK_MHZ(MHZ), .PIN_MIN_US(MUS), .PULSE_CYC(PUL), .STAB_CYC(STB)) uut (
    .clk(clk), .poc_ok(poc_ok), .pin_rst_n(pin_rst_n), .lvd_ok(lvd_ok),
    .wdt_ovf(wdt_ovf), .illegal_op(illegal_op), .debug_mode(debug_mode),
    .cause_ack(cause_ack), .core_rst(core_rst), .osc_stop(osc_stop),
    .ext_clk_en(ext_clk_en), .pins_hiz(pins_hiz), .port_drive_low(port_drive_low),
    .vec_fetch(vec_fetch), .cause(cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [4:0] c);
    exp_q.push_back(c);
  endtask

  // Monitor: compares cause at each vec_fetch with the scoreboard, checks R8 and R10.
  always @(negedge clk) begin
    cyc++;
    if (poc_ok) begin
      if (vec_fetch) begin
        chk("R8 vec_fetch at release", {prev_core, core_rst}, 2'b10);
        if (exp_q.size() == 0) chk("R9 unexpected release", 1, 0);
        else chk("R9 cause at release", int'(cause), int'(exp_q.pop_front()));
      end
      if (pins_hiz && !port_drive_low) chk("R10 port low", 0, 1);
      prev_core = core_rst;
    end
  end

  task automatic wait_run();
    int n = 0;
    while (core_rst && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  // Counts osc_stop cycles, then checks the settle gap (R7).
  task automatic measure(input string req, input int exp_osc);
    int n = 0, s = 0;
    while (!osc_stop && n < 200) begin @(negedge clk); n++; end
    n = 0;
    while (osc_stop && n < 2000) begin @(negedge clk); n++; end
    if (exp_osc >= 0) chk(req, n, exp_osc);
    while (core_rst && !osc_stop && s < 2000) begin @(negedge clk); s++; end
    chk("R7 settle length", s, STB);
  endtask

  task automatic strobe_wdt();
    @(negedge clk); wdt_ovf = 1'b1; @(negedge clk); wdt_ovf = 1'b0;
  endtask

  task automatic no_reset_for(input string req, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (core_rst) seen = 1; end
    chk(req, seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: power-on-clear holds everything
    chk("R11 core_rst in poc", core_rst, 1);
    chk("R11 cause in poc", int'(cause), 5'b00100);
    chk("R1 osc_stop in poc", osc_stop, 1);
    chk("R1 ext_clk_en in poc", ext_clk_en, 0);
    push(5'b00100);
    poc_ok = 1'b1;
    measure("R11 poc hold", -1);
    wait_run();
    // R9: acknowledge clears
    cause_ack = 1'b1; @(negedge clk); cause_ack = 1'b0;
    chk("R9 ack clears", int'(cause), 0);
    // R2: short pin pulse discarded
    pin_rst_n = 1'b0; repeat (MINC / 2) @(negedge clk); pin_rst_n = 1'b1;
    no_reset_for("R2 short pulse ignored", 30);
    // R3: long pin low holds reset
    push(5'b00001);
    pin_rst_n = 1'b0; repeat (MINC + 40) @(negedge clk);
    chk("R3 held while pin low", osc_stop, 1);
    chk("R1 pins_hiz while pin low", pins_hiz, 1);
    pin_rst_n = 1'b1;
    measure("R3 release after pin high", -1);
    wait_run();
    // R4: watchdog self-release, cause replaced
    push(5'b00010);
    fork strobe_wdt(); measure("R4 watchdog stretch", PUL); join
    wait_run();
    // R5: illegal opcode masked in debug
    debug_mode = 1'b1;
    @(negedge clk); illegal_op = 1'b1; @(negedge clk); illegal_op = 1'b0;
    no_reset_for("R5 illegal ignored in debug", 20);
    debug_mode = 1'b0;
    // R4: illegal opcode stretch
    push(5'b10000);
    fork
      begin @(negedge clk); illegal_op = 1'b1; @(negedge clk); illegal_op = 1'b0; end
      measure("R4 illegal stretch", PUL);
    join
    wait_run();
    // R6: low-voltage hold
    push(5'b01000);
    lvd_ok = 1'b0; repeat (40) @(negedge clk);
    chk("R6 held while lvd low", osc_stop, 1);
    lvd_ok = 1'b1;
    measure("R6 lvd release", -1);
    wait_run();
    // R9: watchdog during lvd reset accumulates
    push(5'b01010);
    lvd_ok = 1'b0; repeat (10) @(negedge clk);
    strobe_wdt();
    repeat (5) @(negedge clk);
    lvd_ok = 1'b1;
    measure("R9 accumulate", -1);
    wait_run();
    chk("R9 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    while (!done && cyc < 150000) @(negedge clk);
    if (!done) chk("watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule